// File: doc/BRIEF.md
# TDM Daisy-Chain Slot Forwarder

This block lets several receivers share one time-division multiplexed audio stream that is wired from device to device. It samples up to two serial data lines on the rising edge of the bit clock, captures the first two 32-bit channels of each line for local use, and re-emits each line on a forwarding output delayed by a fixed number of 32-bit channels. The delay depends on the selected frame size. The next device in the chain samples the forwarded line with the same bit and frame clocks. Its own channels then arrive in the first slots of the frame, so every device can run the same slot logic and set of formats.

The delay is always half of the frame. A 512-bit frame is forwarded eight channels late on the first line, and the second forwarding line is held low. A 256-bit frame is forwarded four channels late and a 128-bit frame two channels late, on both lines. With the 64-bit two-channel format selected, or with the chain enable low, both forwarding outputs stay low. The forwarding outputs are launched on the falling edge of the bit clock, half a bit ahead of the downstream sampling edge.

Top module: `tdmfwd_top`

## Requirements
- R1: While reset is held, both forwarding outputs, all four captured channel words and the capture strobe are 0.
- R2: With `fmt`=2'b11 (512-bit frame) and `chain_en`=1, the value on `sdout_a` after the falling edge that follows the rising edge at which input bit k was sampled equals input bit k+1-256 of `sdin_a`. This is a delay of 256 bits (8 channels).
- R3: With `fmt`=2'b11, `sdout_b` is 0 at all times, and the captured words of line B (`loc_b_left`, `loc_b_right`) are 0 whenever a capture completes.
- R4: With `fmt`=2'b10 (256-bit frame) and `chain_en`=1, both `sdout_a` and `sdout_b` carry their input delayed by 128 bits (4 channels), with the same edge rule as R2.
- R5: With `fmt`=2'b01 (128-bit frame) and `chain_en`=1, both forwarding outputs carry their input delayed by 64 bits (2 channels), with the same edge rule as R2.
- R6: With `fmt`=2'b00 (64-bit two-channel frame), or with `chain_en`=0, both forwarding outputs are 0.
- R7: The forwarding outputs change only on the falling edge of `bclk`. Between a rising edge and the next falling edge they keep the value launched at the previous falling edge.
- R8: The 64 bits that follow a frame start (a `fsync` high sample marks bit 0) are shifted in MSB first. Bits 0 to 31 form the left word and bits 32 to 63 the right word of each line. Both words and a one-cycle `loc_valid` pulse appear after the rising edge that samples bit 63.
- R9: Before the first `fsync` after reset, no capture completes and `loc_valid` stays 0, whatever the data lines carry.
- R10: Forwarded bits whose source index falls before the first bit sampled after reset are 0. The forwarded output is therefore zero until the delay line has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; inputs sampled on rising edge, forwarding outputs launched on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame start, high for the bit-clock period of bit 0 of a frame |
| sdin_a | input | 1 | Serial data line A |
| sdin_b | input | 1 | Serial data line B |
| fmt | input | 2 | Frame format: 00 two-channel 64-bit, 01 128-bit, 10 256-bit, 11 512-bit |
| chain_en | input | 1 | Enables forwarding on the chain outputs |
| sdout_a | output | 1 | Forwarded copy of line A |
| sdout_b | output | 1 | Forwarded copy of line B (low in 512-bit frames) |
| loc_a_left | output | 32 | Captured channel 0 of line A |
| loc_a_right | output | 32 | Captured channel 1 of line A |
| loc_b_left | output | 32 | Captured channel 0 of line B |
| loc_b_right | output | 32 | Captured channel 1 of line B |
| loc_valid | output | 1 | One-cycle strobe when a new capture is complete |

## Verification
A forwarded bit sampled at rising edge k is expected half a bit clock later, after falling edge k. Its value is input bit k+1-D, or 0 when that index falls before reset release. The bench reads the output 3 ns after the rising edge to see the new value, and 1 ns after the edge to confirm that the previous value still stands. The captured words and the strobe are due right after the rising edge that samples bit 63 of a frame, and they are read at the same 3 ns point in that period. Every format is swept with the chain enable both high and low. Pseudo-random data runs through a preamble with no frame start, and the expected values are indexed from a stored history of the driven bits.

// File: rtl/tdmfwd_pkg.sv
package tdmfwd_pkg;

    localparam int SLOT_BITS    = 32;
    localparam int MAX_SHIFT_CH = 8;
    localparam int TAP_W        = 9;
    localparam int FRAME_CNT_W  = 10;

    typedef enum logic [1:0] {
        FMT_PAIR = 2'b00,
        FMT_T128 = 2'b01,
        FMT_T256 = 2'b10,
        FMT_T512 = 2'b11
    } tdm_fmt_e;

    typedef struct packed {
        logic             fwd_a;
        logic             fwd_b;
        logic             keep_b;
        logic [TAP_W-1:0] tap;
    } route_s;

    function automatic int shift_channels(tdm_fmt_e fmt);
        case (fmt)
            FMT_T128: return 2;
            FMT_T256: return 4;
            FMT_T512: return 8;
            default:  return 0;
        endcase
    endfunction

    function automatic route_s route_for(tdm_fmt_e fmt, logic en, int slot_w);
        route_s r;
        r.fwd_a  = en && (fmt != FMT_PAIR);
        r.fwd_b  = r.fwd_a && (fmt != FMT_T512);
        r.keep_b = (fmt != FMT_T512);
        r.tap    = TAP_W'(shift_channels(fmt) * slot_w - 1);
        return r;
    endfunction

endpackage

// File: rtl/tdmfwd_delay.sv
module tdmfwd_delay #(
    parameter int DEPTH = 256,
    parameter int SEL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_bit
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] line;
    logic [IDX_W-1:0] idx;
    logic             in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else begin
            line <= {line[DEPTH-2:0], din};
        end
    end

    always_comb begin
        idx      = tap_sel[IDX_W-1:0];
        in_range = (32'(tap_sel) < DEPTH);
        tap_bit  = in_range ? line[idx] : 1'b0;
    end

endmodule

// File: rtl/tdmfwd_framer.sv
module tdmfwd_framer #(
    parameter int CNT_W     = 10,
    parameter int PAIR_BITS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output logic in_pair,
    output logic pair_end,
    output logic cap_strobe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pos;
    logic             locked;
    logic             active;

    always_comb begin
        pos      = fsync ? '0 : cnt;
        active   = fsync | locked;
        in_pair  = active && (32'(pos) < PAIR_BITS);
        pair_end = active && (32'(pos) == PAIR_BITS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '1;
            locked     <= 1'b0;
            cap_strobe <= 1'b0;
        end else begin
            if (fsync) begin
                locked <= 1'b1;
            end
            if (pos != '1) begin
                cnt <= pos + 1'b1;
            end else begin
                cnt <= pos;
            end
            cap_strobe <= pair_end;
        end
    end

endmodule

// File: rtl/tdmfwd_capture.sv
module tdmfwd_capture #(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              load,
    input  logic              blank,
    input  logic              din,
    output logic [SLOT_W-1:0] word_left,
    output logic [SLOT_W-1:0] word_right
);
    localparam int ACC_W = 2 * SLOT_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] nxt;

    always_comb begin
        nxt = {acc[ACC_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            word_left  <= '0;
            word_right <= '0;
        end else begin
            if (shift_en) begin
                acc <= nxt;
            end
            if (load) begin
                if (blank) begin
                    word_left  <= '0;
                    word_right <= '0;
                end else begin
                    word_left  <= nxt[ACC_W-1:SLOT_W];
                    word_right <= nxt[SLOT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/tdmfwd_top.sv
module tdmfwd_top
    import tdmfwd_pkg::*;
#(
    parameter int SLOT_W   = tdmfwd_pkg::SLOT_BITS,
    parameter int SHIFT_CH = tdmfwd_pkg::MAX_SHIFT_CH
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              sdin_a,
    input  logic              sdin_b,
    input  logic [1:0]        fmt,
    input  logic              chain_en,
    output logic              sdout_a,
    output logic              sdout_b,
    output logic [SLOT_W-1:0] loc_a_left,
    output logic [SLOT_W-1:0] loc_a_right,
    output logic [SLOT_W-1:0] loc_b_left,
    output logic [SLOT_W-1:0] loc_b_right,
    output logic              loc_valid
);
    localparam int LANES     = 2;
    localparam int MAX_DLY   = SHIFT_CH * SLOT_W;
    localparam int PAIR_BITS = 2 * SLOT_W;

    route_s              rt;
    logic [LANES-1:0]    din_v;
    logic [LANES-1:0]    tap_v;
    logic [LANES-1:0]    blank_v;
    logic [SLOT_W-1:0]   left_v  [LANES];
    logic [SLOT_W-1:0]   right_v [LANES];
    logic                in_pair;
    logic                pair_end;

    always_comb begin
        rt         = route_for(tdm_fmt_e'(fmt), chain_en, SLOT_W);
        din_v      = {sdin_b, sdin_a};
        blank_v    = {~rt.keep_b, 1'b0};
    end

    tdmfwd_framer #(
        .CNT_W     (FRAME_CNT_W),
        .PAIR_BITS (PAIR_BITS)
    ) u_framer (
        .clk        (bclk),
        .rst        (rst),
        .fsync      (fsync),
        .in_pair    (in_pair),
        .pair_end   (pair_end),
        .cap_strobe (loc_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LANE_DEPTH = (g == 0) ? MAX_DLY : MAX_DLY / 2;

        tdmfwd_delay #(
            .DEPTH (LANE_DEPTH),
            .SEL_W (TAP_W)
        ) u_delay (
            .clk     (bclk),
            .rst     (rst),
            .din     (din_v[g]),
            .tap_sel (rt.tap),
            .tap_bit (tap_v[g])
        );

        tdmfwd_capture #(
            .SLOT_W (SLOT_W)
        ) u_cap (
            .clk        (bclk),
            .rst        (rst),
            .shift_en   (in_pair),
            .load       (pair_end),
            .blank      (blank_v[g]),
            .din        (din_v[g]),
            .word_left  (left_v[g]),
            .word_right (right_v[g])
        );
    end

    always_comb begin
        loc_a_left  = left_v[0];
        loc_a_right = right_v[0];
        loc_b_left  = left_v[1];
        loc_b_right = right_v[1];
    end

    always_ff @(negedge bclk) begin
        if (rst) begin
            sdout_a <= 1'b0;
            sdout_b <= 1'b0;
        end else begin
            sdout_a <= rt.fwd_a & tap_v[0];
            sdout_b <= rt.fwd_b & tap_v[1];
        end
    end

endmodule

// File: rtl/tdmfwd_checker.sv
module tdmfwd_checker #(
    parameter int SLOT_W = 32
) (
    input logic              bclk,
    input logic              rst,
    input logic              fsync,
    input logic [1:0]        fmt,
    input logic              chain_en,
    input logic              sdout_a,
    input logic              sdout_b,
    input logic [SLOT_W-1:0] loc_b_left,
    input logic [SLOT_W-1:0] loc_b_right,
    input logic              loc_valid
);
    logic seen_frame;
    logic fwd_off;

    always_comb begin
        fwd_off = !chain_en || (fmt == 2'b00);
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            seen_frame <= 1'b0;
        end else if (fsync) begin
            seen_frame <= 1'b1;
        end
    end

    assert_out_b_low_R3: assert property (@(posedge bclk) disable iff (rst)
        (fmt == 2'b11 && $past(fmt) == 2'b11) |-> !sdout_b);

    assert_cap_b_zero_R3: assert property (@(posedge bclk) disable iff (rst)
        (fmt == 2'b11 && $past(fmt) == 2'b11 && loc_valid) |->
            (loc_b_left == '0 && loc_b_right == '0));

    assert_fwd_off_low_R6: assert property (@(posedge bclk) disable iff (rst)
        (fwd_off && $past(fwd_off)) |-> (!sdout_a && !sdout_b));

    assert_strobe_single_R8: assert property (@(posedge bclk) disable iff (rst)
        loc_valid |=> !loc_valid);

    assert_no_capture_unlocked_R9: assert property (@(posedge bclk) disable iff (rst)
        loc_valid |-> seen_frame);

endmodule

bind tdmfwd_top tdmfwd_checker #(.SLOT_W(SLOT_W)) u_chk (
    .bclk        (bclk),
    .rst         (rst),
    .fsync       (fsync),
    .fmt         (fmt),
    .chain_en    (chain_en),
    .sdout_a     (sdout_a),
    .sdout_b     (sdout_b),
    .loc_b_left  (loc_b_left),
    .loc_b_right (loc_b_right),
    .loc_valid   (loc_valid)
);

// File: tb/tdmfwd_top_tb.sv
`timescale 1ns/1ps
module tdmfwd_top_tb;

    localparam int PRE  = 70;
    localparam int HMAX = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync = 1'b0;
    logic        sdin_a = 1'b0;
    logic        sdin_b = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        chain_en = 1'b0;
    logic        sdout_a;
    logic        sdout_b;
    logic [31:0] loc_a_left, loc_a_right, loc_b_left, loc_b_right;
    logic        loc_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic h_a [HMAX];
    logic h_b [HMAX];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tdmfwd_top u_dut (
        .bclk        (clk),
        .rst         (rst),
        .fsync       (fsync),
        .sdin_a      (sdin_a),
        .sdin_b      (sdin_b),
        .fmt         (fmt),
        .chain_en    (chain_en),
        .sdout_a     (sdout_a),
        .sdout_b     (sdout_b),
        .loc_a_left  (loc_a_left),
        .loc_a_right (loc_a_right),
        .loc_b_left  (loc_b_left),
        .loc_b_right (loc_b_right),
        .loc_valid   (loc_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (fmt=%0d en=%0d t=%0t)",
                     tag, act, exp, fmt, chain_en, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic logic hist(input bit lane_b, input int idx);
        if (idx < 0) return 1'b0;
        return lane_b ? h_b[idx] : h_a[idx];
    endfunction

    function automatic logic [63:0] pair_from(input bit lane_b, input int k0);
        logic [63:0] v = '0;
        for (int j = 0; j < 64; j++) v = {v[62:0], hist(lane_b, k0 + j)};
        return v;
    endfunction

    task automatic run_config(input int m, input bit en);
        int  frame;
        int  dly;
        int  nbits;
        bit  fwd;
        logic exp_a, exp_b, prev_a, prev_b;
        string tag_a, tag_b;

        frame = (m == 0) ? 64 : (64 << m);
        dly   = (m == 0) ? 0 : (32 << m);
        nbits = PRE + 3 * frame;
        fwd   = en && (m != 0);
        case (m)
            3: begin tag_a = "R2"; tag_b = "R3"; end
            2: begin tag_a = "R4"; tag_b = "R4"; end
            1: begin tag_a = "R5"; tag_b = "R5"; end
            default: begin tag_a = "R6"; tag_b = "R6"; end
        endcase
        if (!en) begin tag_a = "R6"; tag_b = "R6"; end

        for (int k = 0; k < nbits; k++) begin
            h_a[k] = next_bit();
            h_b[k] = next_bit();
        end

        rst = 1'b1; fmt = 2'(m); chain_en = en; sdin_a = 0; sdin_b = 0; fsync = 0;
        repeat (3) @(posedge clk);
        #3;
        chk("R1 sdout", {62'd0, sdout_a, sdout_b}, 64'd0);
        chk("R1 valid", {63'd0, loc_valid}, 64'd0);
        chk("R1 loc_a", {loc_a_left, loc_a_right}, 64'd0);
        chk("R1 loc_b", {loc_b_left, loc_b_right}, 64'd0);
        rst = 1'b0;
        prev_a = 0; prev_b = 0;

        for (int k = 0; k < nbits; k++) begin
            sdin_a = h_a[k];
            sdin_b = h_b[k];
            fsync  = (k >= PRE) && (((k - PRE) % frame) == 0);
            @(posedge clk);
            #1;
            chk("R7 hold", {62'd0, sdout_a, sdout_b}, {62'd0, prev_a, prev_b});
            #2;
            exp_a = fwd ? hist(1'b0, k + 1 - dly) : 1'b0;
            exp_b = (fwd && m != 3) ? hist(1'b1, k + 1 - dly) : 1'b0;
            if (fwd && (k + 1 - dly) < 0) begin
                chk("R10 a", {63'd0, sdout_a}, {63'd0, exp_a});
                if (m != 3) chk("R10 b", {63'd0, sdout_b}, {63'd0, exp_b});
                else        chk("R3 b", {63'd0, sdout_b}, 64'd0);
            end else begin
                chk(tag_a, {63'd0, sdout_a}, {63'd0, exp_a});
                chk(tag_b, {63'd0, sdout_b}, {63'd0, exp_b});
            end
            prev_a = exp_a; prev_b = exp_b;

            if (k < PRE) begin
                chk("R9 valid", {63'd0, loc_valid}, 64'd0);
            end else if (((k - PRE) % frame) == 63) begin
                chk("R8 valid", {63'd0, loc_valid}, 64'd1);
                chk("R8 loc_a", {loc_a_left, loc_a_right}, pair_from(1'b0, k - 63));
                if (m == 3) chk("R3 loc_b", {loc_b_left, loc_b_right}, 64'd0);
                else        chk("R8 loc_b", {loc_b_left, loc_b_right}, pair_from(1'b1, k - 63));
            end else begin
                chk("R8 valid", {63'd0, loc_valid}, 64'd0);
            end
        end
    endtask

    initial begin
        #3;
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                run_config(m, e[0]);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule